// File: doc/BRIEF.md
# 64-bit Width Negotiator for a Parallel Bus Port

This block runs the 64-bit extension handshake on one port of a shared, multiplexed address/data bus. While reset is held it watches the wide-request pin. A low level at the last clock edge of reset means that the upper half of the data path is wired, and the port may negotiate wide transfers. A high level means that the upper half is not connected. In that case the block keeps the upper address/data lines, the upper byte enables and the upper parity line driven to fixed legal levels, so that they never float.

In wide mode the block asserts the wide request when the port starts a transaction as initiator, with the same clock edges as the frame signal. As a target it asserts the wide acknowledge with device-select timing, and only if the initiator is requesting a wide transfer in the claim cycle. Each of these active-low lines is released by driving it high for one cycle before its output enable turns off. A combinational flag reports when the request and the acknowledge are both low in the same cycle, with one of them driven by this port. Arbitration and data movement belong to other blocks. The surrounding logic supplies the start, claim and end strobes.

Top module: `wide_link_negotiator`

## Requirements
- R1: While `rst_n` is low, `req64_oe`, `ack64_oe` and `hi_oe` are all 0 and `wide_o` is 0.
- R2: The port is in wide mode after reset when `req64_n_in` was 0 at the last rising edge of `clk` with `rst_n` low, and in narrow mode when it was 1. The mode holds until the next reset, whatever `req64_n_in` does afterwards.
- R3: In narrow mode, out of reset, `hi_oe` is 1. With the default `PARK_ONES`=0, `hi_ad_o` and `hi_be_o` are all zeros. `hi_par_o` is the XOR of all bits of `hi_ad_o` and `hi_be_o`, so the total count of ones is even.
- R4: In wide mode `hi_oe` is 0.
- R5: In wide mode, with the request driver idle, an `init_start` pulse sampled at a rising edge makes `req64_oe`=1 and `req64_n_o`=0 from that edge on. The values hold until the edge that samples `init_end`.
- R6: In wide mode, a `tgt_claim` pulse is accepted only when `req64_n_in` is 0 in the same cycle. An accepted claim makes `ack64_oe`=1 and `ack64_n_o`=0 from that edge until the edge that samples `tgt_end`. A claim made while `req64_n_in` is 1 leaves `ack64_oe` at 0.
- R7: When an end strobe deasserts a driven line, the line shows oe=1 with value 1 for exactly one cycle. After that its oe is 0.
- R8: In narrow mode `req64_oe` and `ack64_oe` stay 0 for any strobe pattern, and `wide_o` stays 0.
- R9: `wide_o` is 1 exactly when this port drives the request low while `ack64_n_in` is 0, or drives the acknowledge low while `req64_n_in` is 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req64_n_in | input | 1 | Wide-request pin as seen on the bus (active low) |
| ack64_n_in | input | 1 | Wide-acknowledge pin as seen on the bus (active low) |
| init_start | input | 1 | Initiator asserts frame at this edge |
| init_end | input | 1 | Initiator deasserts frame at this edge |
| tgt_claim | input | 1 | Target asserts device select at this edge |
| tgt_end | input | 1 | Target deasserts device select at this edge |
| req64_n_o | output | 1 | Wide-request drive value |
| req64_oe | output | 1 | Wide-request output enable |
| ack64_n_o | output | 1 | Wide-acknowledge drive value |
| ack64_oe | output | 1 | Wide-acknowledge output enable |
| hi_ad_o | output | HI_AD_W | Upper address/data park value |
| hi_be_o | output | HI_BE_W | Upper byte-enable park value |
| hi_par_o | output | 1 | Upper parity park value |
| hi_oe | output | 1 | Output enable for all parked upper lines |
| wide_o | output | 1 | Negotiated 64-bit width flag |

## Verification
If the captured strap is wrong, `hi_oe` shows the wrong level in the first cycle after reset. It also stays wrong for the whole run, and so do the request and acknowledge enables. A driver stuck in a wrong state shows up one edge after the strobe that should have moved it: the line stays driven low, skips its one-cycle high release, or keeps its enable on for a second cycle. A gate that wrongly accepts a claim while no wide request is on the bus drives the acknowledge low in the next cycle. The bench sweeps both strap values, transaction lengths of one to four cycles, and both request levels at claim time.

// File: rtl/wln_pkg.sv
package wln_pkg;
   typedef enum logic [1:0] {
      LINE_IDLE = 2'd0,
      LINE_LOW  = 2'd1,
      LINE_REL  = 2'd2
   } line_state_e;
endpackage

// File: rtl/wln_strap.sv
module wln_strap (
   input  logic clk,
   input  logic rst_n,
   input  logic req_pin_n,
   output logic wide_en
);
   logic wide_q;

   // sampled on every edge during reset; the last one wins and holds
   always_ff @(posedge clk) begin
      if (!rst_n)
         wide_q <= ~req_pin_n;
   end

   assign wide_en = wide_q;
endmodule

// File: rtl/wln_line_drv.sv
module wln_line_drv
   import wln_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic allow_i,
   input  logic set_i,
   input  logic clr_i,
   output logic pin_n_o,
   output logic oe_o,
   output logic low_o
);
   line_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         LINE_IDLE: if (set_i && allow_i) st_d = LINE_LOW;
         LINE_LOW:  if (clr_i)            st_d = LINE_REL;
         LINE_REL:                        st_d = LINE_IDLE;
         default:                         st_d = LINE_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= LINE_IDLE;
      else        st_q <= st_d;
   end

   assign low_o   = (st_q == LINE_LOW);
   assign pin_n_o = ~low_o;
   assign oe_o    = (st_q != LINE_IDLE);
endmodule

// File: rtl/wln_park.sv
module wln_park #(
   parameter int unsigned HI_AD_W   = 32,
   parameter int unsigned HI_BE_W   = 4,
   parameter bit          PARK_ONES = 1'b0
) (
   input  logic               rst_n,
   input  logic               wide_en,
   output logic [HI_AD_W-1:0] ad_o,
   output logic [HI_BE_W-1:0] be_o,
   output logic               par_o,
   output logic               oe_o
);
   generate
      if (PARK_ONES) begin : g_ones
         assign ad_o = '1;
         assign be_o = '1;
      end else begin : g_zeros
         assign ad_o = '0;
         assign be_o = '0;
      end
   endgenerate

   assign par_o = ^{ad_o, be_o};
   assign oe_o  = rst_n & ~wide_en;
endmodule

// File: rtl/wide_link_negotiator.sv
module wide_link_negotiator #(
   parameter int unsigned HI_AD_W   = 32,
   parameter int unsigned HI_BE_W   = 4,
   parameter bit          PARK_ONES = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req64_n_in,
   input  logic               ack64_n_in,
   input  logic               init_start,
   input  logic               init_end,
   input  logic               tgt_claim,
   input  logic               tgt_end,
   output logic               req64_n_o,
   output logic               req64_oe,
   output logic               ack64_n_o,
   output logic               ack64_oe,
   output logic [HI_AD_W-1:0] hi_ad_o,
   output logic [HI_BE_W-1:0] hi_be_o,
   output logic               hi_par_o,
   output logic               hi_oe,
   output logic               wide_o
);
   localparam int unsigned BYTE_LANES = HI_AD_W / 8;

   generate
      if (HI_AD_W == 0 || (HI_AD_W % 8) != 0) begin : g_bad_width
         $error("HI_AD_W must be a non-zero multiple of 8");
      end
      if (HI_BE_W != BYTE_LANES) begin : g_bad_lanes
         $error("HI_BE_W must equal HI_AD_W/8");
      end
   endgenerate

   logic wide_en;
   logic req_low, ack_low;

   wln_strap u_strap (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_pin_n (req64_n_in),
      .wide_en   (wide_en)
   );

   // initiator side: follows frame timing
   wln_line_drv u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .allow_i (wide_en),
      .set_i   (init_start),
      .clr_i   (init_end),
      .pin_n_o (req64_n_o),
      .oe_o    (req64_oe),
      .low_o   (req_low)
   );

   // target side: follows device-select timing, gated by the bus request
   wln_line_drv u_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .allow_i (wide_en & ~req64_n_in),
      .set_i   (tgt_claim),
      .clr_i   (tgt_end),
      .pin_n_o (ack64_n_o),
      .oe_o    (ack64_oe),
      .low_o   (ack_low)
   );

   wln_park #(
      .HI_AD_W   (HI_AD_W),
      .HI_BE_W   (HI_BE_W),
      .PARK_ONES (PARK_ONES)
   ) u_park (
      .rst_n   (rst_n),
      .wide_en (wide_en),
      .ad_o    (hi_ad_o),
      .be_o    (hi_be_o),
      .par_o   (hi_par_o),
      .oe_o    (hi_oe)
   );

   assign wide_o = (req_low & ~ack64_n_in) | (ack_low & ~req64_n_in);
endmodule

// File: rtl/wln_checker.sv
module wln_checker #(
   parameter int unsigned HI_AD_W = 32,
   parameter int unsigned HI_BE_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req64_n_in,
   input logic               ack64_n_in,
   input logic               init_start,
   input logic               tgt_claim,
   input logic               req64_n_o,
   input logic               req64_oe,
   input logic               ack64_n_o,
   input logic               ack64_oe,
   input logic [HI_AD_W-1:0] hi_ad_o,
   input logic [HI_BE_W-1:0] hi_be_o,
   input logic               hi_par_o,
   input logic               hi_oe,
   input logic               wide_o
);
   // R1
   always_comb begin
      if (rst_n === 1'b0)
         a_r1_quiet_in_reset: assert (!req64_oe && !ack64_oe && !hi_oe && !wide_o);
   end

   a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(hi_oe));

   a_r3_park_even: assert property (@(posedge clk) disable iff (!rst_n)
      hi_oe |-> ((^{hi_ad_o, hi_be_o, hi_par_o}) == 1'b0));

   a_r5_req_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_oe && init_start && !req64_oe) |=> (req64_oe && !req64_n_o));

   a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack64_oe && tgt_claim && req64_n_in) |=> !ack64_oe);

   a_r7_req_release_one: assert property (@(posedge clk) disable iff (!rst_n)
      (req64_oe && req64_n_o) |=> !req64_oe);

   a_r7_ack_release_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ack64_oe && ack64_n_o) |=> !ack64_oe);

   a_r7_ack_high_before_off: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack64_oe) |-> $past(ack64_n_o));

   a_r8_narrow_silent: assert property (@(posedge clk) disable iff (!rst_n)
      hi_oe |-> (!req64_oe && !ack64_oe && !wide_o));

   a_r9_wide_both_low: assert property (@(posedge clk) disable iff (!rst_n)
      wide_o |-> (((req64_oe && !req64_n_o) && !ack64_n_in) ||
                  ((ack64_oe && !ack64_n_o) && !req64_n_in)));
endmodule

bind wide_link_negotiator wln_checker #(
   .HI_AD_W (HI_AD_W),
   .HI_BE_W (HI_BE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req64_n_in (req64_n_in),
   .ack64_n_in (ack64_n_in),
   .init_start (init_start),
   .tgt_claim  (tgt_claim),
   .req64_n_o  (req64_n_o),
   .req64_oe   (req64_oe),
   .ack64_n_o  (ack64_n_o),
   .ack64_oe   (ack64_oe),
   .hi_ad_o    (hi_ad_o),
   .hi_be_o    (hi_be_o),
   .hi_par_o   (hi_par_o),
   .hi_oe      (hi_oe),
   .wide_o     (wide_o)
);

// File: tb/sim_wide_link_negotiator.sv
module sim_wide_link_negotiator;
   localparam int CLK_PERIOD = 10;
   localparam int AD_W = 32;
   localparam int BE_W = 4;

   logic clk = 1'b0;
   logic rst_n, req64_n_in, ack64_n_in, init_start, init_end, tgt_claim, tgt_end;
   logic req64_n_o, req64_oe, ack64_n_o, ack64_oe, hi_par_o, hi_oe, wide_o;
   logic [AD_W-1:0] hi_ad_o;
   logic [BE_W-1:0] hi_be_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wide_link_negotiator #(.HI_AD_W(AD_W), .HI_BE_W(BE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req64_n_in(req64_n_in), .ack64_n_in(ack64_n_in),
      .init_start(init_start), .init_end(init_end), .tgt_claim(tgt_claim),
      .tgt_end(tgt_end), .req64_n_o(req64_n_o), .req64_oe(req64_oe),
      .ack64_n_o(ack64_n_o), .ack64_oe(ack64_oe), .hi_ad_o(hi_ad_o),
      .hi_be_o(hi_be_o), .hi_par_o(hi_par_o), .hi_oe(hi_oe), .wide_o(wide_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   task automatic chk_req(input string tag, input bit oe, input bit val);
      chk({tag, " req oe"}, {63'd0, req64_oe}, {63'd0, oe});
      if (oe) chk({tag, " req val"}, {63'd0, req64_n_o}, {63'd0, val});
   endtask

   task automatic chk_ack(input string tag, input bit oe, input bit val);
      chk({tag, " ack oe"}, {63'd0, ack64_oe}, {63'd0, oe});
      if (oe) chk({tag, " ack val"}, {63'd0, ack64_n_o}, {63'd0, val});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; req64_n_in = 1'b1; ack64_n_in = 1'b1;
      init_start = 1'b0; init_end = 1'b0; tgt_claim = 1'b0; tgt_end = 1'b0;
      @(negedge clk);
      for (int s = 0; s < 2; s++) begin
         bit wide;
         wide = (s == 1);
         rst_n = 1'b0;
         // toggle strap during reset; the last edge decides (R2)
         req64_n_in = wide;
         tick();
         req64_n_in = ~wide;
         tick();
         req64_n_in = ~wide;
         init_start = 1'b1; tgt_claim = 1'b1;
         tick();
         chk("R1 reset req oe", {63'd0, req64_oe}, 64'd0);
         chk("R1 reset ack oe", {63'd0, ack64_oe}, 64'd0);
         chk("R1 reset hi oe", {63'd0, hi_oe}, 64'd0);
         chk("R1 reset wide", {63'd0, wide_o}, 64'd0);
         init_start = 1'b0; tgt_claim = 1'b0;
         req64_n_in = wide ? 1'b0 : 1'b1;   // last edge in reset samples this
         tick();
         rst_n = 1'b1;
         req64_n_in = ~req64_n_in;          // opposite value after reset must not matter
         tick();
         chk("R2 strap mode", {63'd0, hi_oe}, {63'd0, !wide});
         req64_n_in = 1'b1;
         if (!wide) begin
            chk("R3 park ad", {32'd0, hi_ad_o}, 64'd0);
            chk("R3 park be", {60'd0, hi_be_o}, 64'd0);
            chk("R3 park parity", {63'd0, hi_par_o}, {63'd0, ^{hi_ad_o, hi_be_o}});
         end else begin
            chk("R4 wide no park", {63'd0, hi_oe}, 64'd0);
         end
         // initiator transactions of length 1..4
         for (int len = 1; len <= 4; len++) begin
            init_start = 1'b1;
            tick();
            init_start = 1'b0;
            for (int k = 0; k < len; k++) begin
               chk_req(wide ? "R5 req low" : "R8 req silent", wide, 1'b0);
               ack64_n_in = (k == len - 1) ? 1'b0 : 1'b1;
               #1;
               chk("R9 wide flag init", {63'd0, wide_o}, {63'd0, wide && (k == len - 1)});
               if (k == len - 1) init_end = 1'b1;
               tick();
            end
            ack64_n_in = 1'b1;
            init_end = 1'b0;
            chk_req(wide ? "R7 req release" : "R8 req silent", wide, 1'b1);
            chk("R2 mode kept", {63'd0, hi_oe}, {63'd0, !wide});
            tick();
            chk_req("R7 req off", 1'b0, 1'b0);
         end
         // target claims with both request levels
         for (int rq = 0; rq < 2; rq++) begin
            bit take;
            take = wide && (rq == 0);
            req64_n_in = rq[0];
            tgt_claim = 1'b1;
            tick();
            tgt_claim = 1'b0;
            chk_ack(wide ? "R6 ack claim" : "R8 ack silent", take, 1'b0);
            chk("R9 wide flag tgt", {63'd0, wide_o}, {63'd0, take});
            req64_n_in = 1'b1;
            #1;
            chk("R9 flag drops with req", {63'd0, wide_o}, 64'd0);
            tick();
            chk_ack("R6 ack held", take, 1'b0);
            tgt_end = 1'b1;
            tick();
            tgt_end = 1'b0;
            chk_ack(take ? "R7 ack release" : "R6 ack idle", take, 1'b1);
            tick();
            chk_ack("R7 ack off", 1'b0, 1'b0);
         end
         // acknowledge seen while idle does not raise the flag
         ack64_n_in = 1'b0; req64_n_in = 1'b0;
         #1;
         chk("R9 idle no flag", {63'd0, wide_o}, 64'd0);
         ack64_n_in = 1'b1; req64_n_in = 1'b1;
         tick();
      end
      finish_run();
   end
endmodule